// File: doc/BRIEF.md
# Translation Regime Context Decoder

This block sits in front of a translation lookaside buffer and its page walker. It takes a snapshot of the system control state: the current exception level, secure state, the virtualization enable, the stage-1 MMU enable and the VMID field of the stage-2 base register. It also takes the code of the translation being requested and the ID of the running context. From these it derives the exception level the translation runs at, the secure and hypervisor flags, the VMID, and three stage-2 routing controls.

Deriving these values costs logic, and it is needed only when the context moves on. So the block caches its result, tagged with the context ID and the translation type. While the tag matches, it keeps presenting the cached result with `ready` high. On a mismatch it drops `ready` for one cycle, captures freshly derived values, and raises `ready` again. Two parameters select the variant. One makes the block the stage-2 decoder, which ignores the translation type when checking its tag. The other removes virtualization support.

Top module: `rtr_ctx_decoder`

## Requirements
- R1: The effective EL follows the translation type code. Codes 4 and 8 give EL0, codes 5 and 9 give EL1, code 6 gives EL2 and code 7 gives EL3. Every other code (0 normal, 1 stage-1-current, 2 nonsecure-both-stages, 3 hyp-mode, 10 to 15) passes `cur_el` through.
- R2: `out_secure` is `sec_state`, cleared when the type code is 3 or 2.
- R3: `out_hyp` is set when the effective EL is 2 or the type code is 3. It is cleared for type codes 2 and 1.
- R4: `out_vmid` equals `s2_base_vmid`, which carries bits 55:48 of the stage-2 base register.
- R5: `out_s2_req` is set in the stage-2 variant. Otherwise it is set when `hcr_vm` is 1, hyp and secure are both clear, the effective EL is below 2, and the type code is neither 1 nor 5.
- R6: `out_s2_desc` follows the R5 rule without the type-code exclusions.
- R7: `out_direct_s2` is set when the block is not the stage-2 variant, `out_s2_req` is set and `sctlr_m` is 0.
- R8: With virtualization support removed, `out_vmid`, `out_hyp`, `out_s2_req`, `out_s2_desc` and `out_direct_s2` are all zero.
- R9: While the cache is valid and `ctx_id` and `xlat_type` keep their cached values, `ready` stays 1. The outputs keep their cached values even when the register inputs change.
- R10: A change of `ctx_id` or `xlat_type` drops `ready` to 0 in that same cycle. After the next clock edge, `ready` is 1 and the outputs hold values derived from the inputs at that edge.
- R11: The stage-2 variant treats a change of `xlat_type` alone as a cache hit.
- R12: Reset clears the cache. `ready` and all outputs are 0, and the first lookup after reset is a recompute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_el | input | 2 | Current exception level from the status register |
| sec_state | input | 1 | Processor is in secure state |
| hcr_vm | input | 1 | Stage-2 translation enable |
| sctlr_m | input | 1 | Stage-1 MMU enable |
| s2_base_vmid | input | 8 | VMID field of the stage-2 base register |
| xlat_type | input | 4 | Translation type code |
| ctx_id | input | CTX_W | Running context identifier |
| out_el | output | 2 | Effective exception level |
| out_secure | output | 1 | Secure translation |
| out_hyp | output | 1 | Hypervisor-regime translation |
| out_vmid | output | 8 | VMID used for tagging |
| out_s2_req | output | 1 | Stage-2 translation required |
| out_s2_desc | output | 1 | Stage-2 needed for descriptor fetches |
| out_direct_s2 | output | 1 | Skip stage 1 and go straight to stage 2 |
| ready | output | 1 | Outputs reflect the presented context |

## Verification
`ready` is combinational from the cache tag. It is due in the same cycle a stimulus is applied: 0 on a miss, 1 on a hit. The derived outputs are registered, so after a miss they are due one clock edge later. Every stimulus is held for two clock periods. The monitor checks `ready` at the falling edge inside the first period and checks the outputs, with `ready` back at 1, at the falling edge inside the second. On a hit the second check expects the older cached values.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int EL_W   = 2;
  localparam int VMID_W = 8;
  localparam int XT_W   = 4;

  typedef enum logic [XT_W-1:0] {
    XT_NORMAL   = 4'd0,
    XT_S1_CUR   = 4'd1,
    XT_S12_NS   = 4'd2,
    XT_HYPCTX   = 4'd3,
    XT_AT_E0    = 4'd4,
    XT_AT_E1    = 4'd5,
    XT_AT_E2    = 4'd6,
    XT_AT_E3    = 4'd7,
    XT_AT12_E0  = 4'd8,
    XT_AT12_E1  = 4'd9
  } xlat_e;

  typedef struct packed {
    logic [EL_W-1:0]   el;
    logic              secure;
    logic              hyp;
    logic [VMID_W-1:0] vmid;
    logic              s2_req;
    logic              s2_desc;
    logic              direct_s2;
  } regime_t;

  localparam int REGIME_W = $bits(regime_t);

  // R1: forced EL for explicit address-translation operations
  function automatic logic [EL_W-1:0] f_eff_el(logic [XT_W-1:0] t,
                                               logic [EL_W-1:0] cur);
    logic [EL_W-1:0] r;
    case (t)
      XT_AT_E0, XT_AT12_E0: r = 2'd0;
      XT_AT_E1, XT_AT12_E1: r = 2'd1;
      XT_AT_E2:             r = 2'd2;
      XT_AT_E3:             r = 2'd3;
      default:              r = cur;
    endcase
    return r;
  endfunction

  // R2
  function automatic logic f_secure(logic [XT_W-1:0] t, logic sec);
    return sec && (t != XT_HYPCTX) && (t != XT_S12_NS);
  endfunction

  // R3
  function automatic logic f_hyp(logic [XT_W-1:0] t, logic [EL_W-1:0] el);
    return ((el == 2'd2) || (t == XT_HYPCTX)) &&
           (t != XT_S12_NS) && (t != XT_S1_CUR);
  endfunction

  // R6: common stage-2 gate
  function automatic logic f_s2_gate(logic vm, logic hyp, logic sec,
                                     logic [EL_W-1:0] el);
    return vm && !hyp && !sec && (el < 2'd2);
  endfunction

  // R5: types that stay in stage 1 only
  function automatic logic f_s2_type_ok(logic [XT_W-1:0] t);
    return (t != XT_S1_CUR) && (t != XT_AT_E1);
  endfunction
endpackage

// File: rtl/rtr_el_map.sv
module rtr_el_map
  import rtr_pkg::*;
#(
  parameter bit HAVE_VIRT = 1'b1
) (
  input  logic [XT_W-1:0] xlat_type,
  input  logic [EL_W-1:0] cur_el,
  input  logic            sec_state,
  output logic [EL_W-1:0] eff_el,
  output logic            eff_secure,
  output logic            eff_hyp
);
  assign eff_el     = f_eff_el(xlat_type, cur_el);
  assign eff_secure = f_secure(xlat_type, sec_state);

  generate
    if (HAVE_VIRT) begin : g_hyp
      assign eff_hyp = f_hyp(xlat_type, eff_el);
    end else begin : g_nohyp
      assign eff_hyp = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rtr_stage2_ctl.sv
module rtr_stage2_ctl
  import rtr_pkg::*;
#(
  parameter bit IS_STAGE2 = 1'b0,
  parameter bit HAVE_VIRT = 1'b1
) (
  input  logic [XT_W-1:0]   xlat_type,
  input  logic [EL_W-1:0]   eff_el,
  input  logic              eff_secure,
  input  logic              eff_hyp,
  input  logic              hcr_vm,
  input  logic              sctlr_m,
  input  logic [VMID_W-1:0] s2_base_vmid,
  output logic [VMID_W-1:0] vmid,
  output logic              s2_req,
  output logic              s2_desc,
  output logic              direct_s2
);
  generate
    if (HAVE_VIRT) begin : g_virt
      logic gate;
      assign gate      = f_s2_gate(hcr_vm, eff_hyp, eff_secure, eff_el);
      assign vmid      = s2_base_vmid;
      assign s2_req    = IS_STAGE2 || (gate && f_s2_type_ok(xlat_type));
      assign s2_desc   = IS_STAGE2 || gate;
      assign direct_s2 = !IS_STAGE2 && s2_req && !sctlr_m;
    end else begin : g_novirt
      assign vmid      = '0;
      assign s2_req    = 1'b0;
      assign s2_desc   = 1'b0;
      assign direct_s2 = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rtr_ctx_cache.sv
module rtr_ctx_cache #(
  parameter int CTX_W       = 8,
  parameter int TYPE_W      = 4,
  parameter int PAYLOAD_W   = 15,
  parameter bit IGNORE_TYPE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTX_W-1:0]     ctx_id,
  input  logic [TYPE_W-1:0]    xlat_type,
  input  logic [PAYLOAD_W-1:0] fresh,
  output logic [PAYLOAD_W-1:0] held,
  output logic                 ready,
  output logic                 recompute
);
  logic                 valid_q;
  logic [CTX_W-1:0]     ctx_q;
  logic [TYPE_W-1:0]    type_q;
  logic [PAYLOAD_W-1:0] held_q;
  logic                 type_match;

  generate
    if (IGNORE_TYPE) begin : g_any_type
      assign type_match = 1'b1;
    end else begin : g_type_tag
      assign type_match = (type_q == xlat_type);
    end
  endgenerate

  assign ready     = valid_q && (ctx_q == ctx_id) && type_match;
  assign recompute = !ready;
  assign held      = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ctx_q   <= '0;
      type_q  <= '0;
      held_q  <= '0;
    end else if (recompute) begin
      valid_q <= 1'b1;
      ctx_q   <= ctx_id;
      type_q  <= xlat_type;
      held_q  <= fresh;
    end
  end
endmodule

// File: rtl/rtr_ctx_decoder.sv
module rtr_ctx_decoder
  import rtr_pkg::*;
#(
  parameter int CTX_W     = 8,
  parameter bit IS_STAGE2 = 1'b0,
  parameter bit HAVE_VIRT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              sec_state,
  input  logic              hcr_vm,
  input  logic              sctlr_m,
  input  logic [VMID_W-1:0] s2_base_vmid,
  input  logic [XT_W-1:0]   xlat_type,
  input  logic [CTX_W-1:0]  ctx_id,
  output logic [EL_W-1:0]   out_el,
  output logic              out_secure,
  output logic              out_hyp,
  output logic [VMID_W-1:0] out_vmid,
  output logic              out_s2_req,
  output logic              out_s2_desc,
  output logic              out_direct_s2,
  output logic              ready
);
  logic [EL_W-1:0]   eff_el;
  logic              eff_secure;
  logic              eff_hyp;
  logic [VMID_W-1:0] nxt_vmid;
  logic              nxt_s2_req;
  logic              nxt_s2_desc;
  logic              nxt_direct;
  regime_t           fresh;
  regime_t           held;
  logic [REGIME_W-1:0] held_bits;
  logic              recompute;

  rtr_el_map #(.HAVE_VIRT(HAVE_VIRT)) u_el (
    .xlat_type  (xlat_type),
    .cur_el     (cur_el),
    .sec_state  (sec_state),
    .eff_el     (eff_el),
    .eff_secure (eff_secure),
    .eff_hyp    (eff_hyp)
  );

  rtr_stage2_ctl #(.IS_STAGE2(IS_STAGE2), .HAVE_VIRT(HAVE_VIRT)) u_s2 (
    .xlat_type    (xlat_type),
    .eff_el       (eff_el),
    .eff_secure   (eff_secure),
    .eff_hyp      (eff_hyp),
    .hcr_vm       (hcr_vm),
    .sctlr_m      (sctlr_m),
    .s2_base_vmid (s2_base_vmid),
    .vmid         (nxt_vmid),
    .s2_req       (nxt_s2_req),
    .s2_desc      (nxt_s2_desc),
    .direct_s2    (nxt_direct)
  );

  always_comb begin
    fresh.el        = eff_el;
    fresh.secure    = eff_secure;
    fresh.hyp       = eff_hyp;
    fresh.vmid      = nxt_vmid;
    fresh.s2_req    = nxt_s2_req;
    fresh.s2_desc   = nxt_s2_desc;
    fresh.direct_s2 = nxt_direct;
  end

  rtr_ctx_cache #(
    .CTX_W       (CTX_W),
    .TYPE_W      (XT_W),
    .PAYLOAD_W   (REGIME_W),
    .IGNORE_TYPE (IS_STAGE2)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx_id    (ctx_id),
    .xlat_type (xlat_type),
    .fresh     (fresh),
    .held      (held_bits),
    .ready     (ready),
    .recompute (recompute)
  );

  assign held          = regime_t'(held_bits);
  assign out_el        = held.el;
  assign out_secure    = held.secure;
  assign out_hyp       = held.hyp;
  assign out_vmid      = held.vmid;
  assign out_s2_req    = held.s2_req;
  assign out_s2_desc   = held.s2_desc;
  assign out_direct_s2 = held.direct_s2;
endmodule

// File: rtl/rtr_chk.sv
module rtr_chk #(
  parameter int CTX_W     = 8,
  parameter bit IS_STAGE2 = 1'b0,
  parameter bit HAVE_VIRT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTX_W-1:0] ctx_id,
  input logic [3:0]       xlat_type,
  input logic [1:0]       out_el,
  input logic             out_secure,
  input logic             out_hyp,
  input logic [7:0]       out_vmid,
  input logic             out_s2_req,
  input logic             out_s2_desc,
  input logic             out_direct_s2,
  input logic             ready,
  input logic             recompute
);
  logic [14:0] outs;
  assign outs = {out_el, out_secure, out_hyp, out_vmid,
                 out_s2_req, out_s2_desc, out_direct_s2};

  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(outs)); // R9

  AST_RECOMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recompute |=> (ready || ctx_id != $past(ctx_id) ||
                   xlat_type != $past(xlat_type))); // R10

  AST_DIRECT_NEEDS_S2: assert property (@(posedge clk) disable iff (!rst_n)
    out_direct_s2 |-> out_s2_req); // R7

  AST_S2_IMPLIES_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    out_s2_req |-> out_s2_desc); // R6

  generate
    if (!IS_STAGE2) begin : g_s1
      AST_S2_BELOW_EL2: assert property (@(posedge clk) disable iff (!rst_n)
        out_s2_req |-> (out_el < 2'd2 && !out_hyp && !out_secure)); // R5
    end else begin : g_s2
      AST_TYPE_ONLY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ctx_id == $past(ctx_id)) |=> (ready || ctx_id != $past(ctx_id))); // R11
    end
    if (!HAVE_VIRT) begin : g_nv
      AST_NOVIRT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_vmid == 8'h0 && !out_hyp && !out_s2_req &&
                   !out_s2_desc && !out_direct_s2)); // R8
    end
  endgenerate
endmodule

bind rtr_ctx_decoder rtr_chk #(
  .CTX_W(CTX_W), .IS_STAGE2(IS_STAGE2), .HAVE_VIRT(HAVE_VIRT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id), .xlat_type(xlat_type),
  .out_el(out_el), .out_secure(out_secure), .out_hyp(out_hyp),
  .out_vmid(out_vmid), .out_s2_req(out_s2_req), .out_s2_desc(out_s2_desc),
  .out_direct_s2(out_direct_s2), .ready(ready), .recompute(recompute)
);

// File: tb/sim_rtr_ctx_decoder.sv
module sim_rtr_ctx_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cur_el = '0;
  logic       sec_state = 1'b0, hcr_vm = 1'b0, sctlr_m = 1'b0;
  logic [7:0] s2_base_vmid = '0;
  logic [3:0] xlat_type = '0;
  logic [7:0] ctx_id = '0;

  always #2.5 clk = ~clk;

  logic [1:0] o_el [3];
  logic       o_sec [3], o_hyp [3], o_rq [3], o_dq [3], o_dr [3], o_rdy [3];
  logic [7:0] o_vmid [3];

  rtr_ctx_decoder #(.IS_STAGE2(1'b0), .HAVE_VIRT(1'b1)) u0 (
    .clk, .rst_n, .cur_el, .sec_state, .hcr_vm, .sctlr_m, .s2_base_vmid,
    .xlat_type, .ctx_id, .out_el(o_el[0]), .out_secure(o_sec[0]),
    .out_hyp(o_hyp[0]), .out_vmid(o_vmid[0]), .out_s2_req(o_rq[0]),
    .out_s2_desc(o_dq[0]), .out_direct_s2(o_dr[0]), .ready(o_rdy[0]));
  rtr_ctx_decoder #(.IS_STAGE2(1'b1), .HAVE_VIRT(1'b1)) u1 (
    .clk, .rst_n, .cur_el, .sec_state, .hcr_vm, .sctlr_m, .s2_base_vmid,
    .xlat_type, .ctx_id, .out_el(o_el[1]), .out_secure(o_sec[1]),
    .out_hyp(o_hyp[1]), .out_vmid(o_vmid[1]), .out_s2_req(o_rq[1]),
    .out_s2_desc(o_dq[1]), .out_direct_s2(o_dr[1]), .ready(o_rdy[1]));
  rtr_ctx_decoder #(.IS_STAGE2(1'b0), .HAVE_VIRT(1'b0)) u2 (
    .clk, .rst_n, .cur_el, .sec_state, .hcr_vm, .sctlr_m, .s2_base_vmid,
    .xlat_type, .ctx_id, .out_el(o_el[2]), .out_secure(o_sec[2]),
    .out_hyp(o_hyp[2]), .out_vmid(o_vmid[2]), .out_s2_req(o_rq[2]),
    .out_s2_desc(o_dq[2]), .out_direct_s2(o_dr[2]), .ready(o_rdy[2]));

  function automatic bit [14:0] obs(int d);
    return {o_el[d], o_sec[d], o_hyp[d], o_vmid[d], o_rq[d], o_dq[d], o_dr[d]};
  endfunction

  localparam bit IS_S2 [3] = '{1'b0, 1'b1, 1'b0};
  localparam bit VIRT  [3] = '{1'b1, 1'b1, 1'b0};

  // Independent restatement of R1..R8, packed el|sec|hyp|vmid|req|desc|direct
  function automatic bit [14:0] mdl(bit s2, bit virt, bit [3:0] t, bit [1:0] ce,
                                    bit sec, bit vm, bit m, bit [7:0] vid);
    bit [1:0] el;
    bit s, h, rq, dq, dr, base;
    if (t == 4 || t == 8)      el = 2'd0;
    else if (t == 5 || t == 9) el = 2'd1;
    else if (t == 6)           el = 2'd2;
    else if (t == 7)           el = 2'd3;
    else                       el = ce;
    s    = sec && !(t == 3 || t == 2);
    h    = virt && (el == 2 || t == 3) && !(t == 2 || t == 1);
    base = vm && !h && !s && el <= 1;
    rq   = virt && (s2 || (base && t != 1 && t != 5));
    dq   = virt && (s2 || base);
    dr   = virt && !s2 && rq && !m;
    return {el, s, h, (virt ? vid : 8'h00), rq, dq, dr};
  endfunction

  typedef struct {
    bit        rdy [3];
    bit [14:0] out [3];
    string     tag;
  } item_t;
  item_t sb_q[$];

  bit        m_valid [3];
  bit [7:0]  m_ctx [3];
  bit [3:0]  m_type [3];
  bit [14:0] m_out [3];

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, int d, bit [14:0] act, bit [14:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s dut%0d actual=%h expected=%h", tag, d, act, exp);
    end
  endtask

  task automatic drive(bit [7:0] c, bit [3:0] t, bit [1:0] ce, bit sec,
                       bit vm, bit m, bit [7:0] vid, string tag);
    item_t it;
    @(posedge clk); #1;
    ctx_id = c; xlat_type = t; cur_el = ce; sec_state = sec;
    hcr_vm = vm; sctlr_m = m; s2_base_vmid = vid;
    for (int d = 0; d < 3; d++) begin
      bit hit;
      hit = m_valid[d] && m_ctx[d] == c && (IS_S2[d] || m_type[d] == t);
      it.rdy[d] = hit;
      if (!hit) begin
        m_valid[d] = 1'b1; m_ctx[d] = c; m_type[d] = t;
        m_out[d] = mdl(IS_S2[d], VIRT[d], t, ce, sec, vm, m, vid);
      end
      it.out[d] = m_out[d];
    end
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        for (int d = 0; d < 3; d++)
          check(o_rdy[d] == it.rdy[d], {it.tag, " ready-now R10"}, d,
                15'(o_rdy[d]), 15'(it.rdy[d]));
        @(negedge clk);
        for (int d = 0; d < 3; d++) begin
          check(o_rdy[d] == 1'b1, {it.tag, " ready-after R10"}, d,
                15'(o_rdy[d]), 15'd1);
          check(obs(d) == it.out[d], it.tag, d, obs(d), it.out[d]);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      summary();
    end
  end

  initial begin : stim
    bit [7:0] c;
    for (int d = 0; d < 3; d++) m_valid[d] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin  // R12 reset state
      check(o_rdy[d] == 1'b0, "R12 reset ready", d, 15'(o_rdy[d]), 15'd0);
      check(obs(d) == 15'd0, "R12 reset outputs", d, obs(d), 15'd0);
    end
    rst_n = 1'b1;
    // R12 first lookup misses; R5/R4 values
    drive(8'd1, 4'd0, 2'd1, 1'b0, 1'b1, 1'b1, 8'h5A, "R12 R5 R4 first");
    // R9: register inputs change, tag unchanged -> cached values persist
    drive(8'd1, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h33, "R9 hit stale");
    // R11: type-only change; stage-2 variant hits, others recompute
    drive(8'd1, 4'd4, 2'd2, 1'b0, 1'b1, 1'b0, 8'h33, "R11 R10 type change");
    drive(8'd1, 4'd5, 2'd2, 1'b0, 1'b1, 1'b0, 8'h44, "R11 type change 2");
    // R10: context change alone forces recompute
    drive(8'd2, 4'd5, 2'd0, 1'b0, 1'b1, 1'b0, 8'h44, "R10 ctx change");
    // R1..R8 sweep over every type code and EL
    c = 8'd10;
    for (int t = 0; t < 16; t++) begin
      for (int e = 0; e < 4; e++) begin
        bit sec, vm, m;
        sec = ((t + e) % 3) == 0;
        vm  = (e != 3);
        m   = t[1] ^ e[0];
        drive(c, 4'(t), 2'(e), sec, vm, m, 8'(t * 17 + e),
              "R1 R2 R3 R4 R5 R6 R7 R8 sweep");
        c++;
      end
    end
    // R7 corner: direct bypass at EL0 nonsecure with MMU off
    drive(8'd200, 4'd0, 2'd0, 1'b0, 1'b1, 1'b0, 8'hC3, "R7 direct");
    // R3/R2: hyp-mode type in secure state
    drive(8'd201, 4'd3, 2'd1, 1'b1, 1'b1, 1'b0, 8'h11, "R2 R3 hypctx");
    repeat (4) @(posedge clk);
    done = 1'b1;
    summary();
  end
endmodule